// File: doc/BRIEF.md
# Framebuffer Control Window Decoder

This block is the write side of the control aperture of an indexed-colour framebuffer. A host issues byte, halfword or word accesses on a simple single-cycle memory-mapped bus. The block breaks each write into up to four little-endian byte lanes at consecutive addresses and decodes every lane independently. Lanes that land in the lowest 2 KiB of the window load one colour component of a 256-entry palette. Lanes at four fixed addresses load slices of the display width and height registers, with each byte shifted into an unusual bit position.

Every write, whether it decodes or not, produces a one-cycle pulse that tells the display pipeline to redraw the full screen. Reads of the window are accepted and answered one cycle later with a zero word. A separate palette lookup port lets the scan-out logic fetch the 24-bit colour of any index with one cycle of latency.

Top module: `fbctl_window`

## Requirements
- R1: A write lane whose 16-bit window address is below 0x0800 loads palette entry address[10:3]. Address[2:0] selects the component: 0 loads red, 1 loads green and 2 loads blue.
- R2: A palette lane whose address[2:0] is 3 to 7 changes no palette entry.
- R3: A lane at 0x0918 replaces width bits [9:2] with the lane byte, and a lane at 0x0919 replaces width bits [17:10]. No other width bit ever becomes nonzero.
- R4: A lane at 0x0940 replaces height bits [6:0] with the lane byte shifted right by one. A lane at 0x0941 replaces height bits [14:7]. No other height bit ever becomes nonzero.
- R5: The size field selects the lanes. 0 is a byte, 1 is a halfword and 2 or 3 is a word. Byte k of the write data goes to window address (base + k) modulo 65536, so the least significant byte takes the lowest address.
- R6: A read (valid with write low) raises rsp_valid in the next cycle with rsp_data equal to zero.
- R7: Every write, decoded or not, raises refresh_req for exactly the following cycle. A cycle without a write leaves it low in the next cycle.
- R8: Asserting rst_n clears every palette entry and sets width and height to zero.
- R9: A lane at or above 0x0800 that is not one of the four dimension addresses changes no state.
- R10: pal_rd_rgb shows, one cycle after pal_rd_idx is presented, the palette entry as it stood in that cycle. Red is in [23:16], green in [15:8] and blue in [7:0].
- R11: Only the low 16 bits of req_addr take part in decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address; only bits [15:0] are decoded |
| req_wdata | input | 32 | Write data, byte k for address base+k |
| rsp_valid | output | 1 | Read answer valid, one cycle after the read |
| rsp_data | output | 32 | Read answer, always zero |
| refresh_req | output | 1 | One-cycle full-redraw request after any write |
| disp_width | output | 32 | Display width register |
| disp_height | output | 32 | Display height register |
| pal_rd_idx | input | 8 | Palette lookup index |
| pal_rd_rgb | output | 24 | Palette lookup result, one cycle latency |

## Verification
The bench goes after the lane corners. Word writes that cover a fourth, unused component slot must leave the neighbouring entry untouched, and a write at 0xFFFE must wrap onto entries at the bottom of the window. A decoder that let component 3 alias onto red, or that carried the lane address into bit 16, would corrupt the palette at these points. The height low byte is written with odd values, so a missing right shift or a dropped bit 0 shows in the height register. Partial updates at each dimension address check that neighbouring slices survive. Writes to undecoded addresses and addresses with high bits set check that refresh still pulses and that no state moves. A mid-run reset checks that the palette is fully cleared.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  // Decoded window is 64 KiB; the bus is at most four bytes wide.
  localparam int WIN_AW = 16;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic              en;
    logic [WIN_AW-1:0] addr;
    logic [7:0]        data;
  } byte_lane_t;

endpackage

// File: rtl/fbctl_rst_sync.sv
module fbctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fbctl_lane_split.sv
module fbctl_lane_split
  import fbctl_pkg::*;
#(
  parameter int BUS_AW = 32,
  parameter int DATA_W = 32
) (
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [1:0]                   req_size,
  input  logic [BUS_AW-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output byte_lane_t [LANES-1:0]       lanes_o
);

  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0]  n_bytes;
  logic [WIN_AW-1:0] base_addr;
  logic              wr_go;

  // Window decode sees only the low address bits.
  assign base_addr = req_addr[WIN_AW-1:0];
  assign wr_go     = req_valid & req_write;

  always_comb begin
    unique case (xfer_size_e'(req_size))
      SZ_BYTE: n_bytes = CNT_W'(1);
      SZ_HALF: n_bytes = CNT_W'(2);
      default: n_bytes = CNT_W'(LANES);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes_o[g].en   = wr_go & (CNT_W'(g) < n_bytes);
    // Address wraps inside the 16-bit window.
    assign lanes_o[g].addr = base_addr + WIN_AW'(g);
    assign lanes_o[g].data = req_wdata[8*g +: 8];
  end

endmodule

// File: rtl/fbctl_palette.sv
module fbctl_palette
  import fbctl_pkg::*;
#(
  parameter int                ENTRIES = 256,
  parameter int                COMPS   = 3,
  parameter int                COMP_W  = 8,
  parameter int                STRIDE  = 8,
  parameter logic [WIN_AW-1:0] LIMIT   = 16'h0800
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  byte_lane_t [LANES-1:0]    lanes_i,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [COMPS*COMP_W-1:0]   rd_rgb
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int SEL_W  = $clog2(STRIDE);
  localparam int CSEL_W = $clog2(COMPS);

  typedef logic [COMPS-1:0][COMP_W-1:0] entry_t;

  entry_t pal_q [ENTRIES];
  entry_t pal_d [ENTRIES];
  logic [ENTRIES-1:0] ent_we;
  entry_t rd_q;

  logic [LANES-1:0]  lane_hit;
  logic [IDX_W-1:0]  lane_idx  [LANES];
  logic [CSEL_W-1:0] lane_comp [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_dec
    logic [SEL_W-1:0] sel;
    assign sel          = lanes_i[l].addr[SEL_W-1:0];
    assign lane_idx[l]  = lanes_i[l].addr[SEL_W +: IDX_W];
    assign lane_comp[l] = sel[CSEL_W-1:0];
    // Stride slots beyond the last component are dropped.
    assign lane_hit[l]  = lanes_i[l].en
                        & (lanes_i[l].addr < LIMIT)
                        & (sel < SEL_W'(COMPS));
  end

  // Next-state: apply every hitting lane; lanes never share an address.
  always_comb begin
    ent_we = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      pal_d[e] = pal_q[e];
    end
    for (int l = 0; l < LANES; l++) begin
      if (lane_hit[l]) begin
        ent_we[lane_idx[l]]                = 1'b1;
        pal_d[lane_idx[l]][lane_comp[l]]   = lanes_i[l].data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        pal_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (ent_we[e]) begin
          pal_q[e] <= pal_d[e];
        end
      end
    end
  end

  // Lookup port: registered, reads the pre-write contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= pal_q[rd_idx];
    end
  end

  // Component 0 (red) is placed in the most significant slot.
  for (genvar c = 0; c < COMPS; c++) begin : g_pack
    assign rd_rgb[(COMPS-1-c)*COMP_W +: COMP_W] = rd_q[c];
  end

endmodule

// File: rtl/fbctl_dims.sv
module fbctl_dims
  import fbctl_pkg::*;
#(
  parameter int                DIM_W  = 32,
  parameter logic [WIN_AW-1:0] W_ADDR = 16'h0918,
  parameter logic [WIN_AW-1:0] H_ADDR = 16'h0940
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  byte_lane_t [LANES-1:0] lanes_i,
  output logic [DIM_W-1:0]       width_o,
  output logic [DIM_W-1:0]       height_o
);

  localparam logic [WIN_AW-1:0] W_ADDR_HI = W_ADDR + WIN_AW'(1);
  localparam logic [WIN_AW-1:0] H_ADDR_HI = H_ADDR + WIN_AW'(1);

  logic [DIM_W-1:0] width_q,  width_d;
  logic [DIM_W-1:0] height_q, height_d;
  logic             dim_we;

  always_comb begin
    width_d  = width_q;
    height_d = height_q;
    dim_we   = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lanes_i[l].en) begin
        if (lanes_i[l].addr == W_ADDR) begin
          width_d[9:2]   = lanes_i[l].data;
          dim_we         = 1'b1;
        end else if (lanes_i[l].addr == W_ADDR_HI) begin
          width_d[17:10] = lanes_i[l].data;
          dim_we         = 1'b1;
        end else if (lanes_i[l].addr == H_ADDR) begin
          height_d[6:0]  = lanes_i[l].data[7:1];
          dim_we         = 1'b1;
        end else if (lanes_i[l].addr == H_ADDR_HI) begin
          height_d[14:7] = lanes_i[l].data;
          dim_we         = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      height_q <= '0;
    end else if (dim_we) begin
      width_q  <= width_d;
      height_q <= height_d;
    end
  end

  assign width_o  = width_q;
  assign height_o = height_q;

endmodule

// File: rtl/fbctl_window.sv
module fbctl_window
  import fbctl_pkg::*;
#(
  parameter int BUS_AW   = 32,
  parameter int DATA_W   = 32,
  parameter int DIM_W    = 32,
  parameter int ENTRIES  = 256,
  parameter int COMP_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [1:0]                    req_size,
  input  logic [BUS_AW-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          refresh_req,
  output logic [DIM_W-1:0]              disp_width,
  output logic [DIM_W-1:0]              disp_height,
  input  logic [$clog2(ENTRIES)-1:0]    pal_rd_idx,
  output logic [3*COMP_W-1:0]           pal_rd_rgb
);

  localparam int COMPS = 3;

  logic                   rst_n_s;
  byte_lane_t [LANES-1:0] lanes;
  logic                   refresh_q, refresh_d;
  logic                   rsp_q, rsp_d;

  fbctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fbctl_lane_split #(.BUS_AW(BUS_AW), .DATA_W(DATA_W)) u_split (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .lanes_o   (lanes)
  );

  fbctl_palette #(
    .ENTRIES (ENTRIES),
    .COMPS   (COMPS),
    .COMP_W  (COMP_W),
    .STRIDE  (8),
    .LIMIT   (16'h0800)
  ) u_pal (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .lanes_i (lanes),
    .rd_idx  (pal_rd_idx),
    .rd_rgb  (pal_rd_rgb)
  );

  fbctl_dims #(
    .DIM_W  (DIM_W),
    .W_ADDR (16'h0918),
    .H_ADDR (16'h0940)
  ) u_dims (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lanes_i  (lanes),
    .width_o  (disp_width),
    .height_o (disp_height)
  );

  // Any write requests a redraw, decoded or not; reads get an empty answer.
  always_comb begin
    refresh_d = req_valid & req_write;
    rsp_d     = req_valid & ~req_write;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      refresh_q <= 1'b0;
      rsp_q     <= 1'b0;
    end else begin
      refresh_q <= refresh_d;
      rsp_q     <= rsp_d;
    end
  end

  assign refresh_req = refresh_q;
  assign rsp_valid   = rsp_q;
  assign rsp_data    = '0;

endmodule

// File: rtl/fbctl_window_chk.sv
module fbctl_window_chk #(
  parameter int BUS_AW  = 32,
  parameter int DATA_W  = 32,
  parameter int DIM_W   = 32,
  parameter int IDX_W   = 8,
  parameter int RGB_W   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [BUS_AW-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              refresh_req,
  input logic [DIM_W-1:0]  disp_width,
  input logic [DIM_W-1:0]  disp_height,
  input logic [IDX_W-1:0]  pal_rd_idx,
  input logic [RGB_W-1:0]  pal_rd_rgb
);

  logic             armed_q;
  logic             prev_wr_q;
  logic [IDX_W-1:0] prev_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      prev_wr_q  <= 1'b0;
      prev_idx_q <= '0;
    end else begin
      armed_q    <= 1'b1;
      prev_wr_q  <= req_valid & req_write;
      prev_idx_q <= pal_rd_idx;
    end
  end

  assert_refresh_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> refresh_req);

  assert_refresh_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !refresh_req);

  assert_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rsp_valid && rsp_data == '0));

  assert_dims_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ($stable(disp_width) && $stable(disp_height)));

  assert_width_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_width[1:0] == 2'b00) && (disp_width >> 18) == '0);

  assert_height_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_height >> 15) == '0);

  assert_lookup_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !prev_wr_q && pal_rd_idx == prev_idx_q) |=> $stable(pal_rd_rgb));

endmodule

bind fbctl_window fbctl_window_chk #(
  .BUS_AW (BUS_AW),
  .DATA_W (DATA_W),
  .DIM_W  (DIM_W),
  .IDX_W  ($clog2(ENTRIES)),
  .RGB_W  (3*COMP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .refresh_req (refresh_req),
  .disp_width  (disp_width),
  .disp_height (disp_height),
  .pal_rd_idx  (pal_rd_idx),
  .pal_rd_rgb  (pal_rd_rgb)
);

// File: tb/fbctl_window_bench.sv
`timescale 1ns/1ps
module fbctl_window_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        refresh_req;
  logic [31:0] disp_width, disp_height;
  logic [7:0]  pal_rd_idx;
  logic [23:0] pal_rd_rgb;

  always #10 clk = ~clk;

  fbctl_window u_fbctl_window (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .refresh_req(refresh_req),
    .disp_width(disp_width), .disp_height(disp_height),
    .pal_rd_idx(pal_rd_idx), .pal_rd_rgb(pal_rd_rgb)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  logic [7:0]  m_pal [256][3];
  logic [31:0] m_w, m_h;

  task automatic model_reset();
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++) m_pal[e][c] = 8'h00;
    m_w = 0;
    m_h = 0;
  endtask

  task automatic model_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) begin
      int unsigned wa;
      logic [7:0] b;
      wa = (a + k) & 32'hFFFF;
      b  = d[8*k +: 8];
      if (wa < 32'h0800) begin
        if ((wa & 7) < 3) m_pal[wa >> 3][wa & 7] = b;
      end else if (wa == 32'h0918) m_w = (m_w & ~32'h0000_03FC) | (32'(b) << 2);
      else if (wa == 32'h0919)     m_w = (m_w & ~32'h0003_FC00) | (32'(b) << 10);
      else if (wa == 32'h0940)     m_h = (m_h & ~32'h0000_007F) | (32'(b) >> 1);
      else if (wa == 32'h0941)     m_h = (m_h & ~32'h0000_7F80) | (32'(b) << 7);
    end
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; compare after the next falling edge.
  task automatic step(input bit v, input bit w, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] d,
                      input logic [7:0] ridx, input string tag);
    logic [23:0] exp_rgb;
    req_valid = v; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    pal_rd_idx = ridx;
    exp_rgb = {m_pal[ridx][0], m_pal[ridx][1], m_pal[ridx][2]};
    if (v && w) model_write(sz, a, d);
    @(posedge clk);
    @(negedge clk);
    cmp({tag, " width R3"},   disp_width,  m_w);
    cmp({tag, " height R4"},  disp_height, m_h);
    cmp({tag, " refresh R7"}, 32'(refresh_req), 32'(v && w));
    cmp({tag, " rspv R6"},    32'(rsp_valid),   32'(v && !w));
    cmp({tag, " rspd R6"},    rsp_data, 32'h0);
    cmp({tag, " rgb R10"},    32'(pal_rd_rgb), 32'(exp_rgb));
  endtask

  task automatic idle(input logic [7:0] ridx, input string tag);
    step(1'b0, 1'b0, 2'd0, 32'h0, 32'h0, ridx, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    pal_rd_idx = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R8: reset state
    cmp("reset width R8",   disp_width, 32'h0);
    cmp("reset height R8",  disp_height, 32'h0);
    cmp("reset refresh R8", 32'(refresh_req), 32'h0);
    cmp("reset rgb R8",     32'(pal_rd_rgb), 32'h0);
    rst_n = 1'b1;
    repeat (3) idle(8'd0, "post-reset");

    // R1: byte writes to entry 5, components R, G, B
    step(1, 1, 2'd0, 32'h0028, 32'h0000_0011, 8'd5, "R1 red");
    step(1, 1, 2'd0, 32'h0029, 32'h0000_0022, 8'd5, "R1 green");
    step(1, 1, 2'd0, 32'h002A, 32'h0000_0033, 8'd5, "R1 blue");
    idle(8'd5, "R1 readback");
    // R2: unused component slots of entry 5
    for (int s = 3; s < 8; s++) step(1, 1, 2'd0, 32'h0028 + s, 32'h0000_00EE, 8'd5, "R2 slot");
    idle(8'd5, "R2 readback");
    idle(8'd6, "R2 neighbour");
    // R5: word write to entry 255, fourth lane hits an unused slot
    step(1, 1, 2'd2, 32'h07F8, 32'hA5C3_B2A1, 8'd255, "R5 word");
    idle(8'd255, "R5 readback");
    step(1, 1, 2'd1, 32'h0010, 32'h0000_7766, 8'd2, "R5 half");
    idle(8'd2, "R5 half readback");
    // R3: width slices
    step(1, 1, 2'd1, 32'h0918, 32'h0000_ABCD, 8'd0, "R3 half");
    step(1, 1, 2'd0, 32'h0919, 32'h0000_0012, 8'd0, "R3 hi byte");
    step(1, 1, 2'd0, 32'h0918, 32'h0000_00FF, 8'd0, "R3 lo byte");
    // R4: height slices with odd values
    step(1, 1, 2'd0, 32'h0940, 32'h0000_00FF, 8'd0, "R4 lo odd");
    step(1, 1, 2'd0, 32'h0941, 32'h0000_0081, 8'd0, "R4 hi");
    step(1, 1, 2'd0, 32'h0940, 32'h0000_0003, 8'd0, "R4 lo small");
    step(1, 1, 2'd3, 32'h0940, 32'hFFFF_5555, 8'd0, "R4 word");
    // R9: undecoded writes still pulse refresh but change nothing
    step(1, 1, 2'd2, 32'h0A00, 32'hFFFF_FFFF, 8'd5, "R9 undecoded");
    step(1, 1, 2'd0, 32'h091A, 32'h0000_0077, 8'd5, "R9 near width");
    step(1, 1, 2'd0, 32'h093F, 32'h0000_0077, 8'd5, "R9 near height");
    // R11: high address bits ignored
    step(1, 1, 2'd0, 32'h0001_0030, 32'h0000_0099, 8'd6, "R11 alias");
    step(1, 1, 2'd0, 32'hABCD_0919, 32'h0000_0003, 8'd6, "R11 alias width");
    idle(8'd6, "R11 readback");
    // R5: wrap at the top of the window
    step(1, 1, 2'd2, 32'h0000_FFFE, 32'h4433_2211, 8'd0, "R5 wrap");
    idle(8'd0, "R5 wrap readback");
    idle(8'd255, "R5 wrap top");
    // R6: reads
    step(1, 0, 2'd2, 32'h0918, 32'h0, 8'd5, "R6 read dims");
    step(1, 0, 2'd0, 32'h0028, 32'h0, 8'd5, "R6 read pal");
    idle(8'd5, "R6 after");

    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 5)       a = $urandom_range(0, 32'h07FF);
      else if (pick < 8)  a = 32'h0918 + $urandom_range(0, 3) + (($urandom_range(0, 1) != 0) ? 32'h28 : 32'h0);
      else                a = $urandom;
      step(1'b1, ($urandom_range(0, 4) != 0), 2'($urandom_range(0, 3)), a, $urandom,
           8'($urandom_range(0, 255)), "mixed R5");
    end

    // R8: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    cmp("mid reset width R8",  disp_width,  32'h0);
    cmp("mid reset height R8", disp_height, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle(8'd0, "R8 settle");
    for (int e = 0; e < 256; e += 17) idle(8'(e), "R8 cleared");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule